// File: doc/BRIEF.md
# EEPROM Page Write Commit Controller

This block sits behind the serial front end of a small EEPROM and owns the write path. A write command supplies a start address and then a stream of data bytes. The block stores these bytes in a one-page buffer, where a page is 32 bytes. The byte offset advances within the page and wraps from the last slot back to the first. When chip select rises, the front end reports how many bits of the current byte had been clocked. The block then decides whether an internal write cycle may start. It may start only when four things hold: the deselect came exactly on a byte boundary, at least one data byte arrived, the write enable latch is set, and the target page lies outside the range selected by the two block-protect bits.

An internal write cycle is modelled by a counter of `CYCLE_CLKS` system clocks, with the write-in-progress flag high for the whole cycle. During the first page-size clocks of a page cycle, the block issues one array write strobe for each buffered slot that actually received a byte. Slots are visited in ascending offset order. A status-register write takes the same cycle length and updates the protect bits, but it issues no array strobes. When any cycle ends, write-in-progress drops and the write enable latch clears. While a cycle runs, every new request is ignored.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `wip`, `wel` and `arrWe` are 0 and `bp` is 2'b00.
- R2: A `wrenReq` pulse while `wip` is 0 sets `wel` at the next clock edge.
- R3: After `wrStart`, each `byteValid` byte is buffered at the next page offset, beginning at `startAddr[4:0]`. A committed cycle writes exactly the received slots, each to address `{startAddr[11:5], offset}`.
- R4: After offset 31 the offset wraps to 0 of the same page, and a later byte overwrites the earlier byte at the same offset.
- R5: At `csRise`, a page write commits only if `csBitCnt` is 0 and at least one byte was received. Otherwise nothing is written, `wip` stays 0 and `wel` is unchanged.
- R6: While `wel` is 0, neither a write commit nor a `wrsrReq` starts a cycle, and `bp` is unchanged.
- R7: Protected addresses depend on `bp`. 00 protects nothing. 01 protects addresses whose bits [11:10] are 11. 10 protects addresses whose bit 11 is 1. 11 protects every address. A commit to a protected page is dropped with no cycle, and `wel` is unchanged.
- R8: On commit, `wip` rises one edge after `csRise` and stays high for exactly `CYCLE_CLKS` clocks. In busy clock j, for j < 32, slot j is strobed if it was received.
- R9: The clock edge that drops `wip` also clears `wel`.
- R10: While `wip` is 1, the inputs `wrenReq`, `wrsrReq`, `wrStart`, `byteValid` and `csRise` have no effect.
- R11: A `wrsrReq` with `wel` set loads `wrsrData` into `bp` at the next edge. It then runs a cycle of `CYCLE_CLKS` clocks with no array strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrenReq | input | 1 | Write-enable command completed (pulse) |
| wrStart | input | 1 | Write command address received (pulse) |
| startAddr | input | 12 | Start address of the write command |
| byteValid | input | 1 | Data byte received (pulse) |
| byteData | input | 8 | Received data byte |
| csRise | input | 1 | Chip select deasserted (pulse) |
| csBitCnt | input | 3 | Bits of the current byte clocked when deselected |
| wrsrReq | input | 1 | Status write completed on a byte boundary (pulse) |
| wrsrData | input | 2 | New protect-bit value |
| arrWe | output | 1 | Array byte write strobe |
| arrAddr | output | 12 | Array write address |
| arrData | output | 8 | Array write data |
| wip | output | 1 | Internal write cycle in progress |
| wel | output | 1 | Write enable latch |
| bp | output | 2 | Block-protect bits |

## Verification
Every request pulse is registered exactly once. `wel`, `bp` and the rise of `wip` therefore show their new value one edge after the pulse. Array strobes for slot j appear in busy clock j, and `wip` and `wel` fall together `CYCLE_CLKS` edges after `wip` rises. The bench drives each pulse just after a falling edge and holds it through one rising edge. It then samples at the following falling edge, so each check lands on the cycle in which the result is due. During a cycle the bench walks one falling edge at a time, recording strobes and counting busy clocks. It compares the recorded order and count against the expected list and length.

// File: rtl/eeprom_commit_pkg.sv
package eeprom_commit_pkg;

  typedef struct packed {
    logic bufClear;
    logic bufStore;
  } bufCtl_t;

  function automatic logic pageProtected(input logic [1:0] bpBits, input logic [1:0] topBits);
    case (bpBits)
      2'b01:   return topBits == 2'b11;
      2'b10:   return topBits[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf
  import eeprom_commit_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  input  logic [OFF_W-1:0]  rdSlot,
  output logic [PAGE_W-1:0] pageAddr,
  output logic              anyValid,
  output logic              slotValid,
  output logic [7:0]        slotData
);

  logic [7:0]            bufData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [OFF_W-1:0]      wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= '0;
      wrPtr    <= '0;
      pageAddr <= '0;
    end else if (ctl.bufClear) begin
      bufValid <= '0;
      wrPtr    <= startAddr[OFF_W-1:0];
      pageAddr <= startAddr[ADDR_W-1:OFF_W];
    end else if (ctl.bufStore) begin
      bufValid[wrPtr] <= 1'b1;
      wrPtr           <= wrPtr + 1'b1;
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctl.bufStore && !ctl.bufClear && wrPtr == OFF_W'(s))
        bufData[s] <= byteData;
    end
  end

  assign anyValid  = |bufValid;
  assign slotValid = bufValid[rdSlot];
  assign slotData  = bufData[rdSlot];

endmodule

// File: rtl/eeprom_commit_ctrl.sv
module eeprom_commit_ctrl
  import eeprom_commit_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrenReq,
  input  logic             wrStart,
  input  logic             byteValid,
  input  logic             csRise,
  input  logic [2:0]       csBitCnt,
  input  logic             wrsrReq,
  input  logic [1:0]       wrsrData,
  input  logic [1:0]       pageTop,
  input  logic             anyValid,
  input  logic             slotValid,
  output bufCtl_t          ctl,
  output logic [OFF_W-1:0] rdSlot,
  output logic             arrWe,
  output logic             wip,
  output logic             wel,
  output logic [1:0]       bp
);

  logic             wrActive;
  logic             pageMode;
  logic [CNT_W-1:0] cnt;
  logic             pageGo;
  logic             lastClk;

  assign pageGo  = (csBitCnt == 3'd0) && anyValid && wel && !pageProtected(bp, pageTop);
  assign lastClk = (cnt == CNT_W'(CYCLE_CLKS - 1));

  assign ctl.bufClear = !wip && wrStart;
  assign ctl.bufStore = !wip && wrActive && byteValid;

  assign rdSlot = cnt[OFF_W-1:0];
  assign arrWe  = wip && pageMode && (cnt < CNT_W'(PAGE_BYTES)) && slotValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wip      <= 1'b0;
      wel      <= 1'b0;
      bp       <= 2'b00;
      wrActive <= 1'b0;
      pageMode <= 1'b0;
      cnt      <= '0;
    end else if (wip) begin
      if (lastClk) begin
        wip <= 1'b0;
        wel <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (wrenReq) wel <= 1'b1;
      if (wrStart) wrActive <= 1'b1;
      if (csRise && wrActive) begin
        wrActive <= 1'b0;
        if (pageGo) begin
          wip      <= 1'b1;
          pageMode <= 1'b1;
          cnt      <= '0;
        end
      end else if (wrsrReq && wel) begin
        bp       <= wrsrData;
        wip      <= 1'b1;
        pageMode <= 1'b0;
        cnt      <= '0;
      end
    end
  end

endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import eeprom_commit_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrenReq,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              csRise,
  input  logic [2:0]        csBitCnt,
  input  logic              wrsrReq,
  input  logic [1:0]        wrsrData,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic              wip,
  output logic              wel,
  output logic [1:0]        bp
);

  bufCtl_t           ctl;
  logic [OFF_W-1:0]  rdSlot;
  logic [PAGE_W-1:0] pageAddr;
  logic              anyValid;
  logic              slotValid;

  eeprom_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .byteData(byteData),
    .rdSlot(rdSlot), .pageAddr(pageAddr), .anyValid(anyValid),
    .slotValid(slotValid), .slotData(arrData)
  );

  eeprom_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrenReq(wrenReq), .wrStart(wrStart), .byteValid(byteValid),
    .csRise(csRise), .csBitCnt(csBitCnt), .wrsrReq(wrsrReq), .wrsrData(wrsrData),
    .pageTop(pageAddr[PAGE_W-1 -: 2]), .anyValid(anyValid), .slotValid(slotValid),
    .ctl(ctl), .rdSlot(rdSlot), .arrWe(arrWe), .wip(wip), .wel(wel), .bp(bp)
  );

  assign arrAddr = {pageAddr, rdSlot};

endmodule

// File: rtl/eeprom_page_commit_chk.sv
module eeprom_page_commit_chk
  import eeprom_commit_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrenReq,
  input logic              wrsrReq,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              wip,
  input logic              wel,
  input logic [1:0]        bp
);

  p_wel_rise_from_wren_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(wrenReq && !wip));

  p_cycle_needs_wel_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> wel);

  p_no_protected_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> !pageProtected(bp, arrAddr[ADDR_W-1 -: 2]));

  p_strobe_in_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> wip);

  p_end_clears_wel_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  p_busy_keeps_bp_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wip && $past(wip)) |-> $stable(bp));

  p_bp_from_wrsr_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bp) |-> $past(wrsrReq && wel && !wip));

endmodule

bind eeprom_page_commit eeprom_page_commit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrenReq(wrenReq), .wrsrReq(wrsrReq), .arrWe(arrWe),
  .arrAddr(arrAddr), .wip(wip), .wel(wel), .bp(bp)
);

// File: tb/eeprom_page_commit_tb.sv
`timescale 1ns/1ps
module eeprom_page_commit_tb;

  localparam int CYC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrenReq = 1'b0, wrStart = 1'b0, byteValid = 1'b0, csRise = 1'b0, wrsrReq = 1'b0;
  logic [11:0] startAddr = '0;
  logic [7:0]  byteData = '0;
  logic [2:0]  csBitCnt = '0;
  logic [1:0]  wrsrData = '0;
  logic        arrWe, wip, wel;
  logic [11:0] arrAddr;
  logic [7:0]  arrData;
  logic [1:0]  bp;

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [11:0] expA [64];
  logic [7:0]  expD [64];
  int          expN;

  eeprom_page_commit #(.ADDR_W(12), .PAGE_BYTES(32), .CYCLE_CLKS(CYC)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int got, input int exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  task automatic doWren();
    wrenReq = 1; @(negedge clk); wrenReq = 0;
  endtask
  task automatic doStart(input logic [11:0] a);
    wrStart = 1; startAddr = a; @(negedge clk); wrStart = 0;
  endtask
  task automatic doByte(input logic [7:0] d);
    byteValid = 1; byteData = d; @(negedge clk); byteValid = 0;
  endtask
  task automatic doCs(input logic [2:0] bits);
    csRise = 1; csBitCnt = bits; @(negedge clk); csRise = 0; csBitCnt = 0;
  endtask
  task automatic doWrsr(input logic [1:0] v);
    wrsrReq = 1; wrsrData = v; @(negedge clk); wrsrReq = 0;
  endtask

  // Called at the negedge after the commit pulse; walks the whole cycle.
  task automatic runCycle(input string req);
    int busy = 0;
    int got = 0;
    logic [11:0] ga [64];
    logic [7:0]  gd [64];
    check(req, "wip rises one edge after commit", wip, 1);
    while (wip && busy < 10 * CYC) begin
      check("R9", "wel held during cycle", wel, 1);
      if (arrWe && got < 64) begin ga[got] = arrAddr; gd[got] = arrData; got++; end
      busy++;
      @(negedge clk);
    end
    check("R8", "busy length", busy, CYC);
    check("R9", "wel cleared with wip", wel, 0);
    check(req, "strobe count", got, expN);
    for (int i = 0; i < expN && i < got; i++) begin
      check(req, $sformatf("addr %0d", i), ga[i], expA[i]);
      check(req, $sformatf("data %0d", i), gd[i], expD[i]);
    end
  endtask

  task automatic expectNoCycle(input string req);
    for (int i = 0; i < 3; i++) begin
      check(req, "no cycle started", wip, 0);
      check(req, "no strobe", arrWe, 0);
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    check("R1", "wip", wip, 0);
    check("R1", "wel", wel, 0);
    check("R1", "bp", bp, 0);
    check("R1", "arrWe", arrWe, 0);
  endtask

  task automatic tWren();
    doWren();
    check("R2", "wel set", wel, 1);
  endtask

  task automatic tByteWrite();
    doStart(12'h123); doByte(8'hA5); doCs(3'd0);
    expN = 1; expA[0] = 12'h123; expD[0] = 8'hA5;
    runCycle("R3");
  endtask

  task automatic tWrap();
    doWren(); doStart(12'h25E);
    for (int i = 0; i < 34; i++) doByte(8'(i + 16));
    doCs(3'd0);
    expN = 32;
    for (int s = 0; s < 32; s++) begin
      expA[s] = 12'h240 + 12'(s);
      expD[s] = (s < 30) ? 8'(s + 2 + 16) : 8'(s + 2 + 16);
    end
    expD[30] = 8'(32 + 16); expD[31] = 8'(33 + 16);
    runCycle("R4");
  endtask

  task automatic tPartial();
    doWren(); doStart(12'h305);
    doByte(8'h11); doByte(8'h22); doByte(8'h33);
    doCs(3'd0);
    expN = 3;
    expA[0] = 12'h305; expD[0] = 8'h11;
    expA[1] = 12'h306; expD[1] = 8'h22;
    expA[2] = 12'h307; expD[2] = 8'h33;
    runCycle("R3");
  endtask

  task automatic tBoundary();
    doWren(); doStart(12'h400); doByte(8'h77); doCs(3'd3);
    expectNoCycle("R5");
    check("R5", "wel kept after misaligned deselect", wel, 1);
    doStart(12'h400); doCs(3'd0);
    expectNoCycle("R5");
    check("R5", "wel kept with no data", wel, 1);
  endtask

  task automatic tNoWel();
    // wel is 1 here; a status write clears it at cycle end.
    doWrsr(2'b00);
    expN = 0; runCycle("R11");
    doStart(12'h500); doByte(8'h99); doCs(3'd0);
    expectNoCycle("R6");
    doWrsr(2'b11);
    expectNoCycle("R6");
    check("R6", "bp unchanged without wel", bp, 0);
  endtask

  task automatic tWrsr();
    doWren(); doWrsr(2'b01);
    check("R11", "bp loaded", bp, 1);
    expN = 0; runCycle("R11");
  endtask

  task automatic protTry(input logic [11:0] a, input bit blocked, input string note);
    doWren(); doStart(a); doByte(8'h5C); doCs(3'd0);
    if (blocked) begin
      expectNoCycle("R7");
      check("R7", {note, " wel kept"}, wel, 1);
    end else begin
      expN = 1; expA[0] = a; expD[0] = 8'h5C;
      runCycle("R7");
    end
  endtask

  task automatic tProtect();
    protTry(12'hC00, 1, "bp01 top quarter");
    protTry(12'hBE0, 0, "bp01 below");
    doWren(); doWrsr(2'b10); expN = 0; runCycle("R11");
    protTry(12'h800, 1, "bp10 upper half");
    protTry(12'h7E0, 0, "bp10 lower half");
    doWren(); doWrsr(2'b11); expN = 0; runCycle("R11");
    protTry(12'h000, 1, "bp11 all");
    doWren(); doWrsr(2'b00); expN = 0; runCycle("R11");
    protTry(12'hFE0, 0, "bp00 none");
  endtask

  task automatic tBusy();
    doWren(); doStart(12'h600); doByte(8'h42); doCs(3'd0);
    check("R10", "cycle running", wip, 1);
    doWren(); doWrsr(2'b11);
    doStart(12'h700); doByte(8'hEE); doCs(3'd0);
    while (wip) @(negedge clk);
    check("R10", "wel after busy wren", wel, 0);
    check("R10", "bp after busy wrsr", bp, 0);
    expectNoCycle("R10");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWren();
    tByteWrite();
    tWrap();
    tPartial();
    tBoundary();
    tNoWel();
    tWrsr();
    tProtect();
    tBusy();
    finishRun();
  end

endmodule